// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire bus slave that sits beside a clock generator and lets a host load its control bytes. It watches SCL and SDA, which arrive already synchronized to the system clock, and drives SDA low only through an open-drain enable. The only transaction it accepts is a block write. The host sends a START, the fixed device address with the write direction, a mandatory command code of zero, and a byte count. Then come the data bytes, which land in the configuration registers in ascending order starting at register 0.

The registers come out of reset with usable defaults, so a system that never talks to the block still gets a working configuration. Register 0 mixes writable controls with read-only views. Its writable controls are a spread-enable bit, a frequency-select bit and one auxiliary stop-control bit. Its read-only views are a live copy of an external stop input and three strap pins captured during reset. Registers 1 and up are plain 8-bit enable masks, written whole.

Top module: `smb_cfg_slave`

## Requirements
- R1: The address byte 8'hD2 (device address 7'h69, direction bit 0 = write) is acknowledged. Any other address byte, including 8'hD3 (read), gets NACK. Every later byte of that transaction then gets NACK and no register changes.
- R2: The byte after the address must be 8'h00. Any other value gets NACK, and the rest of the transaction is ignored.
- R3: The third byte is the count of data bytes. A count from 1 to 32 inclusive is acknowledged. A count of 0 or above 32 gets NACK, and the rest of the transaction is ignored.
- R4: Each byte is received most significant bit first. Each accepted data byte is acknowledged (SDA held low during the ninth clock). Data byte k of a transaction is written to register k, starting at k = 0.
- R5: A data byte whose position is at or beyond the declared count, or at or beyond the number of registers (4 by default), gets NACK. It is not stored, and every later byte of the transaction is ignored.
- R6: A STOP after any whole byte keeps every data byte already acknowledged. A byte cut short by a STOP is discarded. The SDA enable is released on the cycle after a STOP is seen.
- R7: A repeated START at any point abandons the current transaction and starts address decoding again.
- R8: After reset, every writable bit of every register reads 0.
- R9: In register 0, bit 7 is the spread enable (1 = on, also driven on spread_en_o). Bit 5 is the frequency select (1 = alternate, also driven on alt_sel_o). Bit 3 is a writable auxiliary stop control. Bit 6 always reads 0, and writes to it are ignored.
- R10: In register 0, bit 4 shows the level of stop_pin_i one clock earlier. Bits 2 to 0 hold the value of strap_i seen while reset was asserted and do not change afterwards. Writes to bits 4 and 2 to 0 are ignored.
- R11: The SDA enable turns on only while SCL is low, and it never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures the strap pins |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| stop_pin_i | input | 1 | External stop input mirrored into register 0 bit 4 |
| strap_i | input | 3 | Strap pins, captured during reset |
| cfg_regs_o | output | NUM_REGS*8 | All registers, register k at bits [8k+7:8k] |
| spread_en_o | output | 1 | Spread-enable control (register 0 bit 7) |
| alt_sel_o | output | 1 | Alternate frequency select (register 0 bit 5) |

## Verification
The assertions check every cycle that the SDA enable only switches on while SCL is low and never moves while SCL stays high. They also check that the enable drops after a STOP, that writable register bits move only on an SCL falling edge, that the strap bits hold after reset, that bit 4 follows the stop input, and that bit 6 stays zero. Whether a given byte is acknowledged, and which register receives which value, depends on where the byte sits in a transaction. Only the bench's transactions can show that: address, command and count rejection, count and register-range limits, STOP after a partial byte, and repeated START.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_IGNORE
    } txn_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda_bit;
    } bus_evt_t;

    // Writable bits of register 0: spread (7), frequency select (5), aux stop (3)
    localparam logic [7:0] REG0_RW_MASK = 8'hA8;

    function automatic logic count_in_range(input logic [7:0] value, input int max_count);
        return (value != 8'd0) && (int'(value) <= max_count);
    endfunction

endpackage

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smbcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.start    = scl_q & scl_i & sda_q & ~sda_i;
        evt_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
        evt_o.scl_rise = ~scl_q & scl_i;
        evt_o.scl_fall = scl_q & ~scl_i;
        evt_o.sda_bit  = sda_i;
    end
endmodule

// File: rtl/smb_byte_shifter.sv
module smb_byte_shifter
    import smbcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    output logic [7:0] byte_o,
    output logic       byte_done_o,
    output logic       ack_end_o
);
    logic [7:0] shift_q;
    logic [3:0] bit_cnt_q;
    logic       in_ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= 8'd0;
            bit_cnt_q <= 4'd0;
            in_ack_q  <= 1'b0;
        end else if (evt_i.start || evt_i.stop) begin
            bit_cnt_q <= 4'd0;
            in_ack_q  <= 1'b0;
        end else if (evt_i.scl_rise && !in_ack_q && bit_cnt_q < 4'd8) begin
            shift_q   <= {shift_q[6:0], evt_i.sda_bit};
            bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (evt_i.scl_fall) begin
            if (in_ack_q) begin
                in_ack_q  <= 1'b0;
                bit_cnt_q <= 4'd0;
            end else if (bit_cnt_q == 4'd8) begin
                in_ack_q <= 1'b1;
            end
        end
    end

    assign byte_o      = shift_q;
    assign byte_done_o = evt_i.scl_fall && !in_ack_q && (bit_cnt_q == 4'd8)
                         && !evt_i.start && !evt_i.stop;
    assign ack_end_o   = evt_i.scl_fall && in_ack_q;
endmodule

// File: rtl/smb_txn_fsm.sv
module smb_txn_fsm
    import smbcfg_pkg::*;
#(
    parameter int          NUM_REGS  = 4,
    parameter int          MAX_COUNT = 32,
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter logic [7:0]  CMD_CODE  = 8'h00,
    localparam int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int         CNT_W     = $clog2(MAX_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt_i,
    input  logic [7:0]       byte_i,
    input  logic             byte_done_i,
    input  logic             ack_end_i,
    output logic             sda_oe_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o
);
    txn_state_e       state_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] pos_q;
    logic             oe_q;
    logic             ack_now;

    always_comb begin
        unique case (state_q)
            ST_ADDR:  ack_now = (byte_i == {DEV_ADDR, 1'b0});
            ST_CMD:   ack_now = (byte_i == CMD_CODE);
            ST_COUNT: ack_now = count_in_range(byte_i, MAX_COUNT);
            ST_DATA:  ack_now = (remain_q != '0) && (pos_q < CNT_W'(NUM_REGS));
            default:  ack_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            pos_q    <= '0;
            oe_q     <= 1'b0;
        end else if (evt_i.start) begin
            state_q  <= ST_ADDR;
            remain_q <= '0;
            pos_q    <= '0;
            oe_q     <= 1'b0;
        end else if (evt_i.stop) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else if (byte_done_i) begin
            oe_q <= ack_now;
            unique case (state_q)
                ST_ADDR:  state_q <= ack_now ? ST_CMD : ST_IGNORE;
                ST_CMD:   state_q <= ack_now ? ST_COUNT : ST_IGNORE;
                ST_COUNT: begin
                    if (ack_now) begin
                        state_q  <= ST_DATA;
                        remain_q <= byte_i[CNT_W-1:0];
                        pos_q    <= '0;
                    end else begin
                        state_q <= ST_IGNORE;
                    end
                end
                ST_DATA: begin
                    if (ack_now) begin
                        remain_q <= remain_q - 1'b1;
                        pos_q    <= pos_q + 1'b1;
                    end else begin
                        state_q <= ST_IGNORE;
                    end
                end
                default: state_q <= state_q;
            endcase
        end else if (ack_end_i) begin
            oe_q <= 1'b0;
        end
    end

    assign sda_oe_o  = oe_q;
    assign wr_en_o   = byte_done_i && (state_q == ST_DATA) && ack_now
                       && !evt_i.start && !evt_i.stop;
    assign wr_idx_o  = pos_q[IDX_W-1:0];
    assign wr_data_o = byte_i;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smbcfg_pkg::*;
#(
    parameter int  NUM_REGS = 4,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  stop_pin_i,
    input  logic [2:0]            strap_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] rw0_q;
    logic       stop_q;
    logic [2:0] strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rw0_q <= 8'd0;
        end else if (wr_en_i && wr_idx_i == '0) begin
            rw0_q <= wr_data_i & REG0_RW_MASK;
        end
    end

    always_ff @(posedge clk) begin
        stop_q <= stop_pin_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_i;
        end
    end

    assign regs_o[7:0] = {rw0_q[7], 1'b0, rw0_q[5], stop_q, rw0_q[3], strap_q};

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_mask_reg
        logic [7:0] mask_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= 8'd0;
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                mask_q <= wr_data_i;
            end
        end
        assign regs_o[g*8 +: 8] = mask_q;
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smbcfg_pkg::*;
#(
    parameter int         NUM_REGS  = 4,
    parameter int         MAX_COUNT = 32,
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter logic [7:0] CMD_CODE  = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  stop_pin_i,
    input  logic [2:0]            strap_i,
    output logic [NUM_REGS*8-1:0] cfg_regs_o,
    output logic                  spread_en_o,
    output logic                  alt_sel_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_evt_t         evt;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic             ack_end;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic             scl_fall;
    logic             bus_stop;

    smb_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    smb_byte_shifter u_shifter (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .byte_o      (rx_byte),
        .byte_done_o (byte_done),
        .ack_end_o   (ack_end)
    );

    smb_txn_fsm #(
        .NUM_REGS  (NUM_REGS),
        .MAX_COUNT (MAX_COUNT),
        .DEV_ADDR  (DEV_ADDR),
        .CMD_CODE  (CMD_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .byte_i      (rx_byte),
        .byte_done_i (byte_done),
        .ack_end_i   (ack_end),
        .sda_oe_o    (sda_oe_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .stop_pin_i (stop_pin_i),
        .strap_i    (strap_i),
        .regs_o     (cfg_regs_o)
    );

    assign scl_fall    = evt.scl_fall;
    assign bus_stop    = evt.stop;
    assign spread_en_o = cfg_regs_o[7];
    assign alt_sel_o   = cfg_regs_o[5];
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int NUM_REGS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic                  stop_pin_i,
    input logic [NUM_REGS*8-1:0] cfg_regs_o,
    input logic                  scl_fall,
    input logic                  bus_stop
);
    logic [NUM_REGS*8-6:0] rw_view;
    assign rw_view = {cfg_regs_o[NUM_REGS*8-1:8], cfg_regs_o[7], cfg_regs_o[5], cfg_regs_o[3]};

    p_oe_quiet_scl_high_r11: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_i);

    p_release_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !sda_oe_o);

    p_write_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        !scl_fall |=> $stable(rw_view));

    p_strap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_regs_o[2:0]));

    p_stop_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_regs_o[4] == $past(stop_pin_i));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_regs_o[6] == 1'b0);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .stop_pin_i (stop_pin_i),
    .cfg_regs_o (cfg_regs_o),
    .scl_fall   (scl_fall),
    .bus_stop   (bus_stop)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int HALF       = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            m_scl = 1'b1;
    logic            m_sda = 1'b1;
    logic            sda_oe;
    logic            sda_line;
    logic            stop_pin = 1'b0;
    logic [2:0]      strap = 3'b101;
    logic [NREG*8-1:0] regs;
    logic            spread_en;
    logic            alt_sel;

    int vectors = 0;
    int fails   = 0;

    logic [7:0] model [NREG];
    logic [2:0] strap_cap = 3'b101;
    logic [7:0] tx [0:39];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    smb_cfg_slave #(.NUM_REGS(NREG)) u_smb_cfg_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .stop_pin_i  (stop_pin),
        .strap_i     (strap),
        .cfg_regs_o  (regs),
        .spread_en_o (spread_en),
        .alt_sel_o   (alt_sel)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NREG*8-1:0] expected_regs();
        logic [NREG*8-1:0] v;
        v[7:0] = (model[0] & 8'hA8) | {3'b000, stop_pin, 1'b0, strap_cap};
        for (int k = 1; k < NREG; k++) v[k*8 +: 8] = model[k];
        return v;
    endfunction

    task automatic check_regs(input string tag);
        logic [NREG*8-1:0] e;
        hold(2);
        e = expected_regs();
        vectors++;
        if (regs !== e || spread_en !== e[7] || alt_sel !== e[5]) begin
            fails++;
            $display("FAIL %s regs actual=%h expected=%h spread=%b alt=%b", tag, regs, e, spread_en, alt_sel);
        end
    endtask

    task automatic bus_start();
        if (!m_scl) begin
            m_sda = 1'b1; hold(HALF);
            m_scl = 1'b1; hold(HALF);
        end
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b0; hold(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b1; hold(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = b[i]; hold(HALF);
            m_scl = 1'b1; hold(HALF);
            m_scl = 1'b0;
        end
        hold(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        acked = ~sda_line;
        m_scl = 1'b0; hold(HALF);
    endtask

    // Sends tx[0..n-1] after a START; checks each ACK against the rules.
    task automatic run_txn(input int n, input bit end_stop);
        logic dead;
        logic ok;
        logic acked;
        int   cnt;
        string tag;
        dead = 1'b0;
        cnt  = 0;
        bus_start();
        for (int i = 0; i < n; i++) begin
            if (i == 0) begin
                ok = (tx[0] == 8'hD2); tag = "R1";
            end else if (i == 1) begin
                ok = (tx[1] == 8'h00); tag = "R2";
            end else if (i == 2) begin
                ok = (tx[2] >= 8'd1 && tx[2] <= 8'd32); cnt = int'(tx[2]); tag = "R3";
            end else begin
                ok = (i - 3 < cnt) && (i - 3 < NREG);
                tag = ok ? "R4" : "R5";
            end
            ok = ok && !dead;
            if (!ok) dead = 1'b1;
            send_byte(tx[i], acked);
            vectors++;
            if (acked !== ok) begin
                fails++;
                $display("FAIL %s ack byte %0d value %h actual=%b expected=%b", tag, i, tx[i], acked, ok);
            end
            if (ok && i >= 3) model[i-3] = tx[i];
        end
        if (end_stop) bus_stop();
    endtask

    task automatic load3(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n);
        tx[0] = a; tx[1] = c; tx[2] = n;
    endtask

    initial begin
        int seed;
        for (int k = 0; k < NREG; k++) model[k] = 8'h00;
        seed = $urandom(32'd4242);
        hold(5);
        rst = 1'b0;
        strap = 3'b010;
        hold(2);
        check_regs("R8 reset defaults, R10 strap capture");

        // R4: valid block write filling all registers, MSB-first data
        load3(8'hD2, 8'h00, 8'd4);
        tx[3] = 8'hFF; tx[4] = 8'h81; tx[5] = 8'h3C; tx[6] = 8'h5A;
        run_txn(7, 1'b1);
        check_regs("R4 full write, R9 bit6 write ignored, R10 strap write ignored");

        // R1: wrong address and read direction
        load3(8'hD3, 8'h00, 8'd1); tx[3] = 8'h00;
        run_txn(4, 1'b1);
        check_regs("R1 read address ignored");
        load3(8'hD0, 8'h00, 8'd1); tx[3] = 8'h00;
        run_txn(4, 1'b1);
        check_regs("R1 foreign address ignored");

        // R2: bad command code
        load3(8'hD2, 8'h01, 8'd1); tx[3] = 8'h00;
        run_txn(4, 1'b1);
        check_regs("R2 bad command ignored");

        // R3: count boundaries
        load3(8'hD2, 8'h00, 8'd0); tx[3] = 8'h00;
        run_txn(4, 1'b1);
        check_regs("R3 count 0 ignored");
        load3(8'hD2, 8'h00, 8'd33); tx[3] = 8'h00;
        run_txn(4, 1'b1);
        check_regs("R3 count 33 ignored");
        load3(8'hD2, 8'h00, 8'd32);
        for (int k = 3; k < 9; k++) tx[k] = 8'(k * 17);
        run_txn(9, 1'b1);
        check_regs("R3 count 32 accepted, R5 beyond registers");

        // R5: count 1, second data byte refused
        load3(8'hD2, 8'h00, 8'd1); tx[3] = 8'h20; tx[4] = 8'h99;
        run_txn(5, 1'b1);
        check_regs("R5 beyond count not stored");

        // R6: STOP inside a partial byte
        load3(8'hD2, 8'h00, 8'd3); tx[3] = 8'h88; tx[4] = 8'h11;
        run_txn(5, 1'b0);
        send_bits(8'hEE, 5);
        bus_stop();
        check_regs("R6 partial byte discarded");

        // R7: repeated START mid-transaction, then a fresh write
        load3(8'hD2, 8'h00, 8'd2); tx[3] = 8'hA0;
        run_txn(4, 1'b0);
        load3(8'hD2, 8'h00, 8'd2); tx[3] = 8'h08; tx[4] = 8'h77;
        run_txn(5, 1'b1);
        check_regs("R7 repeated start restarts decode");

        // R10: stop input mirror
        stop_pin = 1'b1;
        check_regs("R10 stop pin high");
        stop_pin = 1'b0;
        check_regs("R10 stop pin low");

        // Random transactions
        for (int t = 0; t < 40; t++) begin
            int nd;
            tx[0] = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
            tx[1] = ($urandom % 5 == 0) ? 8'($urandom % 255 + 1) : 8'h00;
            tx[2] = 8'($urandom % 36);
            nd = int'($urandom % 7);
            for (int k = 0; k < nd; k++) tx[3+k] = 8'($urandom);
            stop_pin = 1'($urandom);
            run_txn(3 + nd, 1'b1);
            check_regs("R4 R5 random transaction");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule